// File: doc/BRIEF.md
# SONET Framing Word Aligner

This block sits behind a deserializer in a SONET/SDH receive path. The raw parallel words it receives have no known byte boundary. The block scans the recent bit history at every bit offset for the framing overhead sequence, which is built from the bytes A1 (0xF6) and A2 (0x28). When it finds the sequence, it keeps that offset and uses a barrel shift to turn the raw stream into byte-aligned words. A mode input chooses the short sequence, A1 then A2, or the long sequence, A1 A1 A2 A2.

Lock is confirmed against a fixed frame period, given as a parameter counted in word clocks. The block asserts its sync flag only after the sequence appears again at the same offset exactly one period later. It drops the flag after four expected positions in a row that do not hold the sequence. On every confirmed frame it gives a one-cycle frame-start strobe together with the aligned word that ends the sequence. Software can read the chosen offset from a port for diagnostics.

Top module: `sonet_frame_aligner`

## Requirements
- R1: A synchronous active-high reset clears the aligned data, the frame strobe, the sync flag and the offset to zero.
- R2: The sequence is the bytes A1=0xF6 and A2=0x28, sent most significant bit first. Input bit DW-1 is the earliest bit on the line. With mode_i=0 the pattern is the 16 bits {A1,A2}; with mode_i=1 it is the 32 bits {A1,A1,A2,A2}.
- R3: The sequence is found at any bit alignment, including one that straddles input words. offset_o equals the number of line bits that follow the last bit of the sequence inside the input word that carries that last bit (0 to DW-1).
- R4: Sync is gained when the sequence is seen at the same offset in the input word exactly FRAME_WORDS words after the first sighting. sync_o and frame_o both rise two clock cycles after that word is presented.
- R5: When frame_o is high, data_o holds the last DW line bits of the sequence: 16'hF628 in mode 0 and 16'h2828 in mode 1. The next word holds the two bytes that follow, still byte-aligned.
- R6: frame_o is a single-cycle pulse that occurs only while sync_o is high, once per confirmed frame.
- R7: A single sighting with no repeat one period later never raises sync_o, and the block goes back to searching.
- R8: While synchronised, four expected positions in a row without the sequence drop sync_o two cycles after the fourth such word is presented.
- R9: A sighting at an expected position clears the miss count, so runs of three misses broken by good frames keep sync_o high.
- R10: In mode 1 a stream that has only one A1 byte followed by one A2 byte never gains sync, while mode 0 locks on the same stream.
- R11: The offset does not change while synchronised. After sync is lost, or after a failed confirmation, data keeps flowing through the last chosen offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 0: A1A2 pattern, 1: A1A1A2A2 pattern |
| din_i | input | DW | Raw unaligned word; MSB is the earliest bit |
| data_o | output | DW | Byte-aligned output word |
| frame_o | output | 1 | One-cycle pulse on the word that ends the framing sequence |
| sync_o | output | 1 | Frame synchronisation achieved |
| offset_o | output | $clog2(DW) | Bit offset in use by the barrel shift |

## Verification
A vector table runs both pattern modes with the stream delayed by several bit shifts: zero, a shift that puts the sequence on a word boundary, and shifts that split it across words. The table therefore separates the offset computation, the straddling search and the per-mode pattern choice. Directed streams then cover these cases:
- a header that appears only once;
- headers that disappear for good, which finds the exact frame where sync is lost;
- runs of three missing headers broken by good ones, which shows that the miss count is cleared;
- a stream with only one A1 and one A2 byte, which locks in one mode and not in the other.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  localparam logic [7:0] A1_BYTE = 8'hF6;
  localparam logic [7:0] A2_BYTE = 8'h28;
  localparam logic [15:0] PAT_SHORT = {A1_BYTE, A2_BYTE};
  localparam logic [31:0] PAT_LONG  = {A1_BYTE, A1_BYTE, A2_BYTE, A2_BYTE};

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_LOCK = 2'd2
  } sfa_state_t;
endpackage

// File: rtl/sfa_window.sv
module sfa_window #(
  parameter int DW = 16,
  parameter int NW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    din,
  output logic [NW*DW-1:0] win
);
  // oldest word sits in the top bits, newest in the bottom bits
  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= {win[(NW-1)*DW-1:0], din};
  end
endmodule

// File: rtl/sfa_search.sv
module sfa_search #(
  parameter int DW  = 16,
  parameter int WIN = 48,
  localparam int OW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic [WIN-1:0] win,
  input  logic           mode,
  output logic [DW-1:0]  hit_vec,
  output logic           any_hit,
  output logic [OW-1:0]  hit_off
);
  import sfa_pkg::*;

  // one comparator per bit offset; offset o = bits after pattern end
  for (genvar o = 0; o < DW; o++) begin : g_cmp
    assign hit_vec[o] = mode ? (win[o +: 32] == PAT_LONG)
                             : (win[o +: 16] == PAT_SHORT);
  end

  assign any_hit = |hit_vec;

  // lowest offset wins
  always_comb begin
    hit_off = '0;
    for (int o = DW - 1; o >= 0; o--) begin
      if (hit_vec[o]) hit_off = OW'(o);
    end
  end
endmodule

// File: rtl/sfa_lock.sv
module sfa_lock #(
  parameter int DW          = 16,
  parameter int FRAME_WORDS = 19440,
  parameter int MISS_LIMIT  = 4,
  localparam int OW = (DW > 1) ? $clog2(DW) : 1,
  localparam int CW = $clog2(FRAME_WORDS + 1),
  localparam int MW = $clog2(MISS_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] hit_vec,
  input  logic          any_hit,
  input  logic [OW-1:0] hit_off,
  output logic [OW-1:0] off_q,
  output logic          sync,
  output logic          frame
);
  import sfa_pkg::*;

  sfa_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic [MW-1:0] miss_q;
  logic          frame_q;
  logic          due, hit_here;

  assign due      = (cnt_q == CW'(FRAME_WORDS - 1));
  assign hit_here = hit_vec[off_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      off_q   <= '0;
      cnt_q   <= '0;
      miss_q  <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= 1'b0;
      case (state_q)
        ST_HUNT: begin
          if (any_hit) begin
            off_q   <= hit_off;
            cnt_q   <= '0;
            state_q <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (due) begin
            cnt_q <= '0;
            if (hit_here) begin
              state_q <= ST_LOCK;
              frame_q <= 1'b1;
              miss_q  <= '0;
            end else begin
              state_q <= ST_HUNT;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (due) begin
            cnt_q <= '0;
            if (hit_here) begin
              miss_q  <= '0;
              frame_q <= 1'b1;
            end else if (miss_q == MW'(MISS_LIMIT - 1)) begin
              miss_q  <= '0;
              state_q <= ST_HUNT;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign sync  = (state_q == ST_LOCK);
  assign frame = frame_q;

  p_frame_while_sync_r6: assert property (@(posedge clk) disable iff (rst)
    frame_q |-> (state_q == ST_LOCK));

  p_frame_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    frame_q |=> !frame_q);

  p_miss_below_limit_r8: assert property (@(posedge clk) disable iff (rst)
    miss_q < MW'(MISS_LIMIT));

  p_offset_held_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK) |=> ((state_q != ST_LOCK) || $stable(off_q)));

  p_lock_with_frame_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_LOCK) |-> frame_q);

  p_lock_from_pre_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(state_q == ST_LOCK) |-> ($past(state_q) == ST_PRE));
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner #(
  parameter int DW          = 16,
  parameter int FRAME_WORDS = 19440,
  parameter int MISS_LIMIT  = 4,
  localparam int OW  = (DW > 1) ? $clog2(DW) : 1,
  localparam int NW  = (32 + 2 * DW - 2) / DW,
  localparam int WIN = NW * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] data_o,
  output logic          frame_o,
  output logic          sync_o,
  output logic [OW-1:0] offset_o
);
  logic [WIN-1:0] win;
  logic [DW-1:0]  hit_vec;
  logic           any_hit;
  logic [OW-1:0]  hit_off, off_q;
  logic [DW-1:0]  aligned;

  sfa_window #(.DW(DW), .NW(NW)) u_win (
    .clk(clk), .rst(rst), .din(din_i), .win(win)
  );

  sfa_search #(.DW(DW), .WIN(WIN)) u_search (
    .win(win), .mode(mode_i), .hit_vec(hit_vec),
    .any_hit(any_hit), .hit_off(hit_off)
  );

  sfa_lock #(.DW(DW), .FRAME_WORDS(FRAME_WORDS), .MISS_LIMIT(MISS_LIMIT)) u_lock (
    .clk(clk), .rst(rst), .hit_vec(hit_vec), .any_hit(any_hit),
    .hit_off(hit_off), .off_q(off_q), .sync(sync_o), .frame(frame_o)
  );

  // barrel shift: take the DW bits that end off_q bits above the newest bit
  assign aligned = win[off_q +: DW];

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= aligned;
  end

  assign offset_o = off_q;

  p_no_frame_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> sync_o);

  p_sync_drop_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |-> !frame_o);
endmodule

// File: tb/test_sonet_frame_aligner.sv
module test_sonet_frame_aligner;
  localparam int DW = 16;
  localparam int FW = 20;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] data_o;
  logic          frame_o, sync_o;
  logic [OW-1:0] offset_o;

  sonet_frame_aligner #(.DW(DW), .FRAME_WORDS(FW), .MISS_LIMIT(4)) i_sonet_frame_aligner (
    .clk(clk), .rst(rst), .mode_i(mode), .din_i(din),
    .data_o(data_o), .frame_o(frame_o), .sync_o(sync_o), .offset_o(offset_o)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;

  // stream description
  int          cur_s, cur_hdr;
  logic [31:0] cur_mask;

  // recorded results
  int          pulse_cnt, first_pulse, first_sync, drop_at, frame_unlocked;
  logic [DW-1:0] data_first, data_next;
  logic          frame_next;
  logic [OW-1:0] off_first;

  localparam int VEC [0:6][0:2] = '{
    '{0, 0, 8}, '{0, 3, 5}, '{0, 8, 0}, '{0, 13, 11},
    '{1, 0, 0}, '{1, 5, 11}, '{1, 15, 1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(int j);
    int f = j / (FW * 2);
    int p = j % (FW * 2);
    if (f < 32 && cur_mask[f]) return 8'h00;
    if (p < cur_hdr) return 8'hF6;
    if (p < 2 * cur_hdr) return 8'h28;
    return 8'h00;
  endfunction

  function automatic logic bit_at(int b);
    logic [7:0] by;
    if (b < cur_s) return 1'b0;
    by = byte_at((b - cur_s) / 8);
    return by[7 - ((b - cur_s) % 8)];
  endfunction

  function automatic logic [DW-1:0] word_at(int n);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[DW-1-i] = bit_at(n * DW + i);
    return w;
  endfunction

  function automatic int end_bit(int f);
    int endbits = mode ? (cur_hdr + 2) * 8 : (cur_hdr + 1) * 8;
    return cur_s + f * FW * DW + endbits - 1;
  endfunction

  function automatic int kword(int f);
    return end_bit(f) / DW;
  endfunction

  function automatic int exp_off();
    return DW - 1 - (end_bit(0) % DW);
  endfunction

  task automatic do_reset(input bit check);
    @(negedge clk);
    rst = 1'b1;
    din = '0;
    repeat (3) @(negedge clk);
    if (check) begin
      chk(data_o == '0, "R1 data", data_o, 0);
      chk(!frame_o && !sync_o, "R1 flags", {frame_o, sync_o}, 0);
      chk(offset_o == '0, "R1 offset", offset_o, 0);
    end
    rst = 1'b0;
  endtask

  task automatic run(input int nwords);
    pulse_cnt = 0; first_pulse = -1; first_sync = -1; drop_at = -1;
    frame_unlocked = 0; frame_next = 1'b0;
    data_first = '0; data_next = '0; off_first = '0;
    for (int n = 0; n < nwords; n++) begin
      @(negedge clk);
      if (frame_o) begin
        pulse_cnt++;
        if (!sync_o) frame_unlocked++;
        if (first_pulse < 0) begin
          first_pulse = n; data_first = data_o; off_first = offset_o;
        end
      end
      if (first_pulse >= 0 && n == first_pulse + 1) begin
        data_next = data_o; frame_next = frame_o;
      end
      if (sync_o && first_sync < 0) first_sync = n;
      if (first_sync >= 0 && !sync_o && drop_at < 0) drop_at = n;
      din = word_at(n);
    end
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state
    do_reset(1'b1);

    // vector table: mode, bit shift, expected offset
    for (int v = 0; v < 7; v++) begin
      mode = VEC[v][0][0];
      cur_s = VEC[v][1]; cur_hdr = 4; cur_mask = '0;
      do_reset(1'b0);
      run(4 * FW + 4);
      chk(off_first == OW'(VEC[v][2]), "R3 offset", off_first, VEC[v][2]);
      chk(VEC[v][2] == exp_off(), "R3 offset model", VEC[v][2], exp_off());
      chk(first_pulse == kword(1) + 2, "R4 first frame", first_pulse, kword(1) + 2);
      chk(first_sync == first_pulse, "R4 sync with frame", first_sync, first_pulse);
      chk(data_first == (mode ? 16'h2828 : 16'hF628), "R2 R5 pattern word",
          data_first, mode ? 16'h2828 : 16'hF628);
      chk(data_next == 16'h2828, "R5 following word", data_next, 16'h2828);
      chk(!frame_next, "R6 pulse width", frame_next, 0);
      chk(pulse_cnt == 3 && frame_unlocked == 0, "R6 pulse count", pulse_cnt, 3);
    end

    // single sighting only
    mode = 1'b0; cur_s = 6; cur_hdr = 4; cur_mask = 32'hFFFF_FFFE;
    do_reset(1'b0);
    run(4 * FW + 4);
    chk(first_sync < 0 && pulse_cnt == 0, "R7 no lock", first_sync, -1);
    chk(offset_o == OW'(exp_off()), "R11 offset kept after failed confirm", offset_o, exp_off());

    // permanent loss from frame 3
    mode = 1'b0; cur_s = 5; cur_hdr = 4; cur_mask = 32'hFFFF_FFF8;
    do_reset(1'b0);
    run(kword(6) + 6);
    chk(pulse_cnt == 2, "R8 pulses before loss", pulse_cnt, 2);
    chk(drop_at == kword(6) + 2, "R8 drop timing", drop_at, kword(6) + 2);
    chk(offset_o == OW'(exp_off()), "R11 offset after loss", offset_o, exp_off());

    // runs of three misses broken by good frames
    mode = 1'b1; cur_s = 9; cur_hdr = 4;
    cur_mask = 32'h0000_0738;  // frames 3,4,5 and 8,9,10 missing
    do_reset(1'b0);
    run(12 * FW + 4);
    chk(drop_at < 0, "R9 sync kept", drop_at, -1);
    chk(pulse_cnt == 5, "R9 pulse count", pulse_cnt, 5);

    // reset while synchronised
    @(negedge clk);
    chk(sync_o, "R9 still locked", sync_o, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!sync_o && offset_o == '0 && data_o == '0 && !frame_o, "R1 reset while locked",
        {sync_o, offset_o}, 0);
    rst = 1'b0;

    // single A1 / A2 bytes: long pattern must not lock, short one must
    mode = 1'b1; cur_s = 2; cur_hdr = 1; cur_mask = '0;
    do_reset(1'b0);
    run(4 * FW + 4);
    chk(first_sync < 0, "R10 long pattern no lock", first_sync, -1);
    mode = 1'b0;
    do_reset(1'b0);
    run(4 * FW + 4);
    chk(first_pulse == kword(1) + 2, "R10 short pattern locks", first_pulse, kword(1) + 2);
    chk(off_first == OW'(exp_off()), "R10 R3 short pattern offset", off_first, exp_off());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule